// File: doc/BRIEF.md
# Free-Running 64-bit Timebase with Windowed Views

This block keeps a 64-bit count that rises by one on every clock edge from the moment reset is released. Software reaches it over a simple word-addressed read and write port. The count can be read as seven overlapping 32-bit windows, each at a coarser resolution than the one before. It can also be read as one consistent 64-bit value: reading the lowest window latches the upper half into a holding register in the same cycle.

Two compare channels each watch a programmable slice of the count. A slice has a start bit from 0 to 31 and a width from 1 to 32 bits. When the slice equals the low bits of the channel's compare word, the channel sets a sticky flag. The flag drives the channel's interrupt line while its enable bit is set, and software clears it by writing a 1 to it. A control bit can stop the count to save power, and a freeze input holds it during debug. Reads keep working while the count is stopped or frozen.

Top module: `tbase64_timer`

## Requirements
- R1: While running, the count increases by exactly one per clock edge, and it wraps from all-ones to zero.
- R2: After reset, the count, `rd_data` and `irq` are zero, and the count starts rising on the first edge after reset is released, with no write needed.
- R3: Writing 1 to bit 0 of address 8 (control) holds the count. Writing 0 resumes counting from the held value.
- R4: A read of address n, for n from 0 to 5, returns count bits [4n+31:4n]. A read of address 6 returns bits [63:32].
- R5: A read of address 0 copies count bits [63:32] into a holding register in the same cycle. Address 7 returns that copy, so the pair {address 7, address 0} equals the count at the cycle of the address-0 read, even across a carry.
- R6: While `freeze` is high the count does not change, and all reads still return current values.
- R7: Address 11 configures the channel slices. Channel c takes its start bit from bits [16c+4:16c] and its width minus one from bits [16c+12:16c+8]. Addresses 9 and 10 hold the compare words for channels 0 and 1. A channel's flag is set one edge after a count advance that makes the slice equal the masked compare word. A matching value that was loaded, or that is held by freeze, does not set the flag.
- R8: Bit c of address 12 enables channel c. `irq[c]` is high only while the flag and the enable are both set. A read of address 12 returns the enables in bits [1:0] and the flags in bits [9:8].
- R9: Writing 1 to bit c of address 13 clears flag c. A set caused by a match on the same edge takes priority over the clear.
- R10: A write to address 14 replaces count bits [31:0], and a write to address 15 replaces bits [63:32]. The count does not advance on the edge of the write.
- R11: Read data appears on `rd_data` one edge after `rd_en`, and it is zero on any edge that had no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Debug hold; while high the count stops |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| irq | output | 2 | Per-channel interrupt, flag AND enable |

## Verification
The windows are swept over several 64-bit patterns: a stepped nibble pattern, all-ones, the two end bits alone, and alternating bits. Each pattern tells apart a wrong offset, a wrong direction or a wrong final window. Coherent reads start just below a low-half carry and read after zero to three extra counts, so a captured half taken from the wrong cycle shows up at once. The direct high window read in the same sequence is expected to disagree once the carry has passed. Compare channels run with a narrow slice at bit 0 over 45 counts, where exactly three events must appear. They also run with an offset 8-bit slice whose compare word has junk in its upper bits, and with a full 32-bit slice. A final case, a match value held by freeze after a clear, separates a flag that responds to advances from one that responds to levels.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   localparam int unsigned ADR_W      = 4;
   localparam logic [3:0] ADR_CAPHI   = 4'd7;
   localparam logic [3:0] ADR_CTRL    = 4'd8;
   localparam logic [3:0] ADR_CMPV0   = 4'd9;
   localparam logic [3:0] ADR_SLCFG   = 4'd11;
   localparam logic [3:0] ADR_IRQ     = 4'd12;
   localparam logic [3:0] ADR_CLR     = 4'd13;
   localparam logic [3:0] ADR_LDLO    = 4'd14;
   localparam logic [3:0] ADR_LDHI    = 4'd15;

   typedef struct packed {
      logic [4:0] start;
      logic [4:0] wlen_m1;
   } slice_cfg_t;
endpackage

// File: rtl/tbase_count.sv
module tbase_count #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [HALF_W-1:0] ld_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              advanced
);
   if (CNT_W != 2 * HALF_W) begin : g_bad_half
      $error("tbase_count: CNT_W must be twice HALF_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         advanced <= 1'b0;
      end else begin
         advanced <= 1'b0;
         if (ld_lo || ld_hi) begin
            if (ld_lo) cnt[HALF_W-1:0]     <= ld_data;
            if (ld_hi) cnt[CNT_W-1:HALF_W] <= ld_data;
         end else if (run) begin
            cnt      <= cnt + 1'b1;
            advanced <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tbase_views.sv
module tbase_views #(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned VIEW_W  = 32,
   parameter int unsigned STEP    = 4,
   parameter int unsigned N_VIEWS = 7
) (
   input  logic [CNT_W-1:0]                 cnt,
   output logic [N_VIEWS-1:0][VIEW_W-1:0]   views
);
   localparam int unsigned TOP_LSB = CNT_W - VIEW_W;

   if (N_VIEWS < 2) begin : g_bad_n
      $error("tbase_views: need at least two views");
   end
   if (STEP * (N_VIEWS - 2) + VIEW_W > CNT_W) begin : g_bad_step
      $error("tbase_views: stepped windows exceed the count width");
   end

   for (genvar n = 0; n < N_VIEWS; n++) begin : g_view
      if (n == N_VIEWS - 1) begin : g_top
         assign views[n] = cnt[TOP_LSB +: VIEW_W];
      end else begin : g_step
         assign views[n] = cnt[STEP * n +: VIEW_W];
      end
   end
endmodule

// File: rtl/tbase_cmp.sv
module tbase_cmp #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned CMP_W = 32,
   parameter int unsigned OFS_W = $clog2(CMP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              advanced,
   input  logic [CMP_W-1:0]  cmp_val,
   input  logic [OFS_W-1:0]  start,
   input  logic [OFS_W-1:0]  wlen_m1,
   input  logic              en,
   input  logic              clr,
   output logic              flag,
   output logic              irq
);
   if ((1 << OFS_W) > CMP_W * 2 || (1 << OFS_W) < CMP_W) begin : g_bad_ofs
      $error("tbase_cmp: OFS_W must fit CMP_W");
   end
   if ((1 << OFS_W) - 1 + CMP_W > CNT_W) begin : g_bad_reach
      $error("tbase_cmp: slice can run past the count");
   end

   logic [CMP_W-1:0] mask;
   logic [CMP_W-1:0] slice;
   logic             hit;

   always_comb begin
      mask  = {CMP_W{1'b1}} >> (CMP_W - 1 - int'(wlen_m1));
      slice = CMP_W'(cnt >> start);
      hit   = ((slice ^ cmp_val) & mask) == '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (hit && advanced)  flag <= 1'b1;
      else if (clr)              flag <= 1'b0;
   end

   assign irq = flag & en;
endmodule

// File: rtl/tbase64_timer.sv
module tbase64_timer
   import tbase_pkg::*;
#(
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned VIEW_W    = 32,
   parameter int unsigned VIEW_STEP = 4,
   parameter int unsigned N_VIEWS   = 7,
   parameter int unsigned N_CH      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic              rd_en,
   input  logic [ADR_W-1:0]  rd_addr,
   output logic [VIEW_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADR_W-1:0]  wr_addr,
   input  logic [VIEW_W-1:0] wr_data,
   output logic [N_CH-1:0]   irq
);
   localparam int unsigned HALF_W = CNT_W / 2;
   localparam int unsigned OFS_W  = $clog2(VIEW_W);
   localparam int unsigned CFG_STRIDE = 16;

   if (N_CH < 1 || N_CH > 2) begin : g_bad_ch
      $error("tbase64_timer: one or two compare channels supported");
   end
   if (VIEW_W != HALF_W) begin : g_bad_view
      $error("tbase64_timer: view width must be half the count");
   end
   if (OFS_W != 5 || N_VIEWS > int'(ADR_CAPHI)) begin : g_bad_map
      $error("tbase64_timer: parameters do not fit the address map");
   end

   logic [CNT_W-1:0]              cnt_w;
   logic                          adv_w;
   logic                          off_q;
   logic                          ld_lo, ld_hi, ld_any;
   logic [N_VIEWS-1:0][VIEW_W-1:0] views_w;
   logic [VIEW_W-1:0]             cap_q;
   logic [N_CH-1:0][VIEW_W-1:0]   cmp_q;
   slice_cfg_t [N_CH-1:0]         cfg_q;
   logic [N_CH-1:0]               en_q;
   logic [N_CH-1:0]               clr_w;
   logic [N_CH-1:0]               flag_w;
   logic [VIEW_W-1:0]             rd_next;
   logic                          rd_low;

   assign ld_lo  = wr_en && (wr_addr == ADR_LDLO);
   assign ld_hi  = wr_en && (wr_addr == ADR_LDHI);
   assign ld_any = ld_lo || ld_hi;
   assign rd_low = rd_en && (rd_addr == '0);
   assign clr_w  = {N_CH{wr_en && (wr_addr == ADR_CLR)}} & wr_data[N_CH-1:0];

   tbase_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (!off_q && !freeze),
      .ld_lo    (ld_lo),
      .ld_hi    (ld_hi),
      .ld_data  (wr_data),
      .cnt      (cnt_w),
      .advanced (adv_w)
   );

   tbase_views #(
      .CNT_W(CNT_W), .VIEW_W(VIEW_W), .STEP(VIEW_STEP), .N_VIEWS(N_VIEWS)
   ) u_views (
      .cnt   (cnt_w),
      .views (views_w)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tbase_cmp #(.CNT_W(CNT_W), .CMP_W(VIEW_W), .OFS_W(OFS_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt      (cnt_w),
         .advanced (adv_w),
         .cmp_val  (cmp_q[c]),
         .start    (cfg_q[c].start),
         .wlen_m1  (cfg_q[c].wlen_m1),
         .en       (en_q[c]),
         .clr      (clr_w[c]),
         .flag     (flag_w[c]),
         .irq      (irq[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= 1'b0;
         cmp_q <= '0;
         cfg_q <= '0;
         en_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL) off_q <= wr_data[0];
         if (wr_addr == ADR_IRQ)  en_q  <= wr_data[N_CH-1:0];
         for (int c = 0; c < N_CH; c++) begin
            if (wr_addr == ADR_CMPV0 + 4'(c)) cmp_q[c] <= wr_data;
            if (wr_addr == ADR_SLCFG) begin
               cfg_q[c].start   <= wr_data[CFG_STRIDE*c +: 5];
               cfg_q[c].wlen_m1 <= wr_data[CFG_STRIDE*c + 8 +: 5];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (rd_low) cap_q <= cnt_w[CNT_W-1:HALF_W];
   end

   always_comb begin
      rd_next = '0;
      for (int v = 0; v < N_VIEWS; v++) begin
         if (rd_addr == ADR_W'(v)) rd_next = views_w[v];
      end
      if (rd_addr == ADR_CAPHI) rd_next = cap_q;
      if (rd_addr == ADR_CTRL)  rd_next[0] = off_q;
      for (int c = 0; c < N_CH; c++) begin
         if (rd_addr == ADR_CMPV0 + 4'(c)) rd_next = cmp_q[c];
         if (rd_addr == ADR_SLCFG) begin
            rd_next[CFG_STRIDE*c +: 5]     = cfg_q[c].start;
            rd_next[CFG_STRIDE*c + 8 +: 5] = cfg_q[c].wlen_m1;
         end
         if (rd_addr == ADR_IRQ) begin
            rd_next[c]     = en_q[c];
            rd_next[8 + c] = flag_w[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_en ? rd_next : '0;
   end
endmodule

// File: rtl/tbase64_timer_chk.sv
module tbase64_timer_chk #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned VIEW_W = 32,
   parameter int unsigned N_CH   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              freeze,
   input logic              off_q,
   input logic              ld_any,
   input logic [CNT_W-1:0]  cnt,
   input logic              adv,
   input logic              rd_en,
   input logic [3:0]        rd_addr,
   input logic [VIEW_W-1:0] cap,
   input logic [VIEW_W-1:0] rd_data,
   input logic [N_CH-1:0]   irq,
   input logic [N_CH-1:0]   en,
   input logic [N_CH-1:0]   flag
);
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!freeze && !off_q && !ld_any)) |-> cnt == $past(cnt) + 1'b1);

   assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(off_q && !ld_any)) |-> $stable(cnt));

   assert_cap_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_en && rd_addr == 4'd0)) |-> cap == $past(cnt[CNT_W-1:VIEW_W]));

   assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(freeze && !ld_any)) |-> $stable(cnt));

   assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ((flag & ~$past(flag)) != '0)) |-> $past(adv));

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~en) == '0);

   assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rd_en)) |-> rd_data == '0);
endmodule

bind tbase64_timer tbase64_timer_chk #(
   .CNT_W(CNT_W), .VIEW_W(VIEW_W), .N_CH(N_CH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .freeze  (freeze),
   .off_q   (off_q),
   .ld_any  (ld_any),
   .cnt     (cnt_w),
   .adv     (adv_w),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .cap     (cap_q),
   .rd_data (rd_data),
   .irq     (irq),
   .en      (en_q),
   .flag    (flag_w)
);

// File: tb/test_tbase64_timer.sv
module test_tbase64_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tbase64_timer i_tbase64_timer (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; rd_addr = a;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic load64(input logic [63:0] v);
      wr(4'd14, v[31:0]);
      wr(4'd15, v[63:32]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, hc, hv;
      logic [63:0] pats [4];
      logic [63:0] base;
      int ev0, bad1;
      pats[0] = 64'h0123_4567_89AB_CDEF;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h8000_0000_0000_0001;
      pats[3] = 64'h5A5A_A5A5_3C3C_C3C3;

      repeat (4) @(negedge clk);
      chk("R2 rd_data in reset", 64'(rd_data), 64'd0);
      chk("R2 irq in reset", 64'(irq), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd(4'd0, v);
      chk("R2 auto start count", 64'(v), 64'd3);
      freeze = 1'b1;
      rd(4'd0, v);
      chk("R1 single step", 64'(v), 64'd4);
      @(negedge clk);
      chk("R11 idle read data", 64'(rd_data), 64'd0);

      // R4 window sweep
      foreach (pats[p]) begin
         load64(pats[p]);
         for (int n = 0; n < 7; n++) begin
            rd(4'(n), v);
            if (n == 6) chk("R4 top window", 64'(v), pats[p] >> 32);
            else        chk("R4 stepped window", 64'(v), (pats[p] >> (4 * n)) & 64'hFFFF_FFFF);
         end
      end
      chk("R10 load both halves", 64'(v), 64'h5A5A_A5A5);

      // R1 wrap
      load64('1);
      freeze = 1'b0;
      @(negedge clk);
      freeze = 1'b1;
      rd(4'd0, v);
      chk("R1 wrap low", 64'(v), 64'd0);
      rd(4'd6, v);
      chk("R1 wrap high", 64'(v), 64'd0);

      // R3 power-off hold and resume
      load64(64'h100);
      wr(4'd8, 32'd1);
      freeze = 1'b0;
      repeat (10) @(negedge clk);
      rd(4'd0, v);
      chk("R3 held while off", 64'(v), 64'h100);
      wr(4'd8, 32'd0);
      repeat (5) @(negedge clk);
      freeze = 1'b1;
      rd(4'd0, v);
      chk("R3 resume after on", 64'(v), 64'h105);

      // R6 freeze hold, reads still served
      load64(64'h0000_0009_0000_0077);
      repeat (10) @(negedge clk);
      rd(4'd0, v);
      chk("R6 frozen low", 64'(v), 64'h77);
      rd(4'd7, v);
      chk("R6 frozen capture read", 64'(v), 64'h9);
      rd(4'd6, v);
      chk("R6 frozen top window", 64'(v), 64'h9);

      // R5 coherent read across the low-half carry
      for (int d = 0; d < 4; d++) begin
         base = 64'h0000_0005_FFFF_FFFD;
         freeze = 1'b1;
         load64(base);
         freeze = 1'b0;
         repeat (d) @(negedge clk);
         rd(4'd0, v);
         rd(4'd7, hc);
         rd(4'd6, hv);
         freeze = 1'b1;
         chk("R5 coherent pair", {hc, v}, base + 64'(d));
         chk("R4 direct top read later", 64'(hv), (base + 64'(d + 2)) >> 32);
      end

      // R7 R8 R9 narrow slice, enable gating, clear
      load64(64'd0);
      wr(4'd11, 32'h0300_0300);
      wr(4'd9, 32'd5);
      wr(4'd10, 32'd7);
      wr(4'd12, 32'd1);
      wr(4'd13, 32'd3);
      ev0 = 0; bad1 = 0;
      freeze = 1'b0;
      for (int i = 0; i < 45; i++) begin
         @(negedge clk);
         if (irq[1]) bad1++;
         if (irq[0]) begin
            ev0++;
            wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'd1;
         end else begin
            wr_en = 1'b0;
         end
      end
      wr_en = 1'b0;
      freeze = 1'b1;
      chk("R7 R9 one event per match", 64'(ev0), 64'd3);
      chk("R8 disabled channel silent", 64'(bad1), 64'd0);
      rd(4'd12, v);
      chk("R8 status enables and flags", 64'(v), 64'h201);

      // R7 only advances set the flag
      wr(4'd13, 32'd3);
      load64(64'h14);
      freeze = 1'b0;
      @(negedge clk);
      freeze = 1'b1;
      @(negedge clk);
      chk("R7 advance into match", 64'(irq[0]), 64'd1);
      wr(4'd13, 32'd1);
      repeat (5) @(negedge clk);
      chk("R7 R9 held match stays clear", 64'(irq[0]), 64'd0);

      // R7 offset slice with junk above the width
      wr(4'd11, 32'h0000_0708);
      wr(4'd9, 32'hFFFF_FFAB);
      load64(64'hAAFD);
      wr(4'd13, 32'd3);
      freeze = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 offset slice before", 64'(irq[0]), 64'd0);
      @(negedge clk);
      freeze = 1'b1;
      chk("R7 offset slice hit", 64'(irq[0]), 64'd1);

      // R7 full-width slice
      wr(4'd11, 32'h0000_1F00);
      wr(4'd9, 32'h0000_1235);
      load64(64'h1233);
      wr(4'd13, 32'd3);
      freeze = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 full width before", 64'(irq[0]), 64'd0);
      @(negedge clk);
      freeze = 1'b1;
      chk("R7 full width hit", 64'(irq[0]), 64'd1);
      rd(4'd11, v);
      chk("R7 config readback", 64'(v), 64'h1F00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule